// File: doc/BRIEF.md
# Pipelined 8-point integer DCT

This block turns a vector of eight signed integer samples into the eight coefficients of an orthonormal DCT-II. All eight samples arrive side by side on one wide input together with a qualifying valid bit. The eight coefficients leave side by side, each a signed fixed-point number with six fractional bits, exactly four clocks later. The pipeline accepts a new vector on every clock and never stalls, so a row engine of a 2D transform or a streaming filter bank can feed it one vector per cycle.

Inside, the first stage forms the sums and differences of mirrored sample pairs. The sums feed an even branch that reduces to a 4-point and then a 2-point transform. The differences feed an odd branch of weighted rotation sums. The cosine weights are fixed 16-bit constants with 15 fractional bits, and the 1/sqrt(2) normalisation of the DC term is folded into its weight. Products are accumulated at full Q15 precision. The nine lowest fractional bits are dropped only in the last stage, which truncates toward minus infinity. A valid bit moves through a reset-cleared shift register in step with the data, so no status logic is needed.

Top module: `dct8_pipe_core`

## Requirements
- R1: Sample n (n = 0..7) is the signed two's-complement field `in_samples[8n+7:8n]`. Coefficient k (k = 0..7) is the signed field `out_coefs[20k+19:20k]`, in Q6 format (value times 64).
- R2: `out_valid` in any cycle equals `in_valid` sampled four rising edges earlier, whatever the data.
- R3: While the synchronous active-high `rst` is sampled high, every stage valid is cleared. From the edge after the first such edge, `out_valid` stays low until a vector accepted after reset has passed through all four stages. This holds even when `in_valid` is high during reset.
- R4: Vectors presented on consecutive cycles are all accepted, and each produces exactly one output cycle.
- R5: Each AC coefficient k (k = 1..7) is within 3 LSB of 64 * 0.5 * sum over n of x[n]*cos((2n+1)k*pi/16).
- R6: The DC coefficient is within 3 LSB of 64 * sum(x[n]) / sqrt(8). For example, all samples at 127 give about 22989, and all at -128 give about -23170.
- R7: A mirror-symmetric input (x[n] = x[7-n] for all n) gives exactly zero on all odd coefficients.
- R8: A mirror-antisymmetric input (x[n] = -x[7-n] for all n) gives exactly zero on all even coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Qualifies the sample vector in this cycle |
| in_samples | input | 64 | Eight signed 8-bit samples, sample n at bits 8n+7:8n |
| out_valid | output | 1 | Qualifies the coefficient vector in this cycle |
| out_coefs | output | 160 | Eight signed 20-bit Q6 coefficients, coefficient k at bits 20k+19:20k |

## Verification
The bench builds the block with its default parameters: 8-bit samples, a 20-bit output and 9 dropped bits, which gives a 29-bit accumulator. Under these settings the full-scale vectors (all -128, all 127, and alternating extremes) drive the products and the rotation sums to their largest magnitudes. This shows whether any stage loses a carry or a sign bit. The exact-zero cases for mirror-symmetric and mirror-antisymmetric vectors need no rounding tolerance at these widths, so a misrouted pair or a wrong weight sign shows up as a nonzero value. Bursts with gaps and a reset in the middle of a full pipeline are checked against the four-cycle valid shift.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

    localparam int LANES   = 8;
    localparam int HALF    = LANES / 2;
    localparam int LAT     = 4;
    localparam int CONST_W = 16;
    localparam int FRAC_W  = 15;

    // Q15 weights, each already multiplied by the 0.5 output scale
    // round(0.5 * cos(m*pi/16) * 2^15); the DC weight is round(2^15 / (2*sqrt(2)))
    localparam logic signed [CONST_W-1:0] W_DC = 16'sd11585;
    localparam logic signed [CONST_W-1:0] W_C1 = 16'sd16069;
    localparam logic signed [CONST_W-1:0] W_C2 = 16'sd15137;
    localparam logic signed [CONST_W-1:0] W_C3 = 16'sd13623;
    localparam logic signed [CONST_W-1:0] W_C5 = 16'sd9102;
    localparam logic signed [CONST_W-1:0] W_C6 = 16'sd6270;
    localparam logic signed [CONST_W-1:0] W_C7 = 16'sd3196;

    // Signed weight applied to difference term col for odd output row
    // (row 0..3 gives coefficient 1,3,5,7)
    function automatic logic signed [CONST_W-1:0] odd_weight(input int row, input int col);
        logic signed [CONST_W-1:0] w;
        w = '0;
        case (row)
            0: case (col)
                   0:       w = W_C1;
                   1:       w = W_C3;
                   2:       w = W_C5;
                   default: w = W_C7;
               endcase
            1: case (col)
                   0:       w = W_C3;
                   1:       w = -W_C7;
                   2:       w = -W_C1;
                   default: w = -W_C5;
               endcase
            2: case (col)
                   0:       w = W_C5;
                   1:       w = -W_C1;
                   2:       w = W_C7;
                   default: w = W_C3;
               endcase
            default: case (col)
                   0:       w = W_C7;
                   1:       w = -W_C5;
                   2:       w = W_C3;
                   default: w = -W_C1;
               endcase
        endcase
        return w;
    endfunction

endpackage

// File: rtl/dct8_input_bfly.sv
module dct8_input_bfly
    import dct8_pkg::*;
#(
    parameter int IN_W = 8,
    localparam int S1_W = IN_W + 1
) (
    input  logic                   clk,
    input  logic signed [IN_W-1:0] samp_i [LANES],
    output logic signed [S1_W-1:0] sum_q  [HALF],
    output logic signed [S1_W-1:0] diff_q [HALF]
);

    // Stage 1: mirrored pair sums and differences
    for (genvar i = 0; i < HALF; i++) begin : g_pair
        always_ff @(posedge clk) begin
            sum_q[i]  <= S1_W'(samp_i[i]) + S1_W'(samp_i[LANES-1-i]);
            diff_q[i] <= S1_W'(samp_i[i]) - S1_W'(samp_i[LANES-1-i]);
        end
    end

endmodule

// File: rtl/dct8_even_path.sv
module dct8_even_path
    import dct8_pkg::*;
#(
    parameter int S1_W   = 9,
    parameter int OUT_W  = 20,
    parameter int DROP_W = 9,
    localparam int S2_W  = S1_W + 1,
    localparam int ACC_W = OUT_W + DROP_W
) (
    input  logic                    clk,
    input  logic signed [S1_W-1:0]  sum_i  [HALF],
    output logic signed [OUT_W-1:0] coef_q [HALF]   // coefficients 0,2,4,6
);

    localparam logic signed [ACC_W-1:0] KX_DC = ACC_W'(W_DC);
    localparam logic signed [ACC_W-1:0] KX_C2 = ACC_W'(W_C2);
    localparam logic signed [ACC_W-1:0] KX_C6 = ACC_W'(W_C6);

    // Stage 2: 4-point split
    logic signed [S2_W-1:0] a_q [HALF];
    always_ff @(posedge clk) begin
        a_q[0] <= S2_W'(sum_i[0]) + S2_W'(sum_i[3]);
        a_q[1] <= S2_W'(sum_i[1]) + S2_W'(sum_i[2]);
        a_q[2] <= S2_W'(sum_i[1]) - S2_W'(sum_i[2]);
        a_q[3] <= S2_W'(sum_i[0]) - S2_W'(sum_i[3]);
    end

    logic signed [ACC_W-1:0] ax [HALF];
    for (genvar i = 0; i < HALF; i++) begin : g_ext
        assign ax[i] = ACC_W'(a_q[i]);
    end

    // Stage 3: 2-point transform plus rotation products
    logic signed [ACC_W-1:0] p_dc_q, p_ac4_q, p2a_q, p2b_q, p6a_q, p6b_q;
    always_ff @(posedge clk) begin
        p_dc_q  <= (ax[0] + ax[1]) * KX_DC;
        p_ac4_q <= (ax[0] - ax[1]) * KX_DC;
        p2a_q   <= ax[3] * KX_C2;
        p2b_q   <= ax[2] * KX_C6;
        p6a_q   <= ax[3] * KX_C6;
        p6b_q   <= ax[2] * KX_C2;
    end

    // Stage 4: combine and drop the low fractional bits
    logic signed [ACC_W-1:0] acc [HALF];
    always_comb begin
        acc[0] = p_dc_q;
        acc[1] = p2a_q + p2b_q;
        acc[2] = p_ac4_q;
        acc[3] = p6a_q - p6b_q;
    end

    for (genvar j = 0; j < HALF; j++) begin : g_out
        always_ff @(posedge clk) begin
            coef_q[j] <= OUT_W'(acc[j] >>> DROP_W);
        end
    end

endmodule

// File: rtl/dct8_odd_path.sv
module dct8_odd_path
    import dct8_pkg::*;
#(
    parameter int S1_W   = 9,
    parameter int OUT_W  = 20,
    parameter int DROP_W = 9,
    localparam int ACC_W = OUT_W + DROP_W
) (
    input  logic                    clk,
    input  logic signed [S1_W-1:0]  diff_i [HALF],
    output logic signed [OUT_W-1:0] coef_q [HALF]   // coefficients 1,3,5,7
);

    // Stage 2: sign-extend and align with the even branch
    logic signed [ACC_W-1:0] dx_q [HALF];
    for (genvar i = 0; i < HALF; i++) begin : g_dly
        always_ff @(posedge clk) begin
            dx_q[i] <= ACC_W'(diff_i[i]);
        end
    end

    for (genvar j = 0; j < HALF; j++) begin : g_rot
        localparam logic signed [ACC_W-1:0] WX0 = ACC_W'(odd_weight(j, 0));
        localparam logic signed [ACC_W-1:0] WX1 = ACC_W'(odd_weight(j, 1));
        localparam logic signed [ACC_W-1:0] WX2 = ACC_W'(odd_weight(j, 2));
        localparam logic signed [ACC_W-1:0] WX3 = ACC_W'(odd_weight(j, 3));

        logic signed [ACC_W-1:0] part_lo_q, part_hi_q, total;

        // Stage 3: two partial weighted sums
        always_ff @(posedge clk) begin
            part_lo_q <= dx_q[0] * WX0 + dx_q[1] * WX1;
            part_hi_q <= dx_q[2] * WX2 + dx_q[3] * WX3;
        end

        assign total = part_lo_q + part_hi_q;

        // Stage 4: final sum, truncation toward minus infinity
        always_ff @(posedge clk) begin
            coef_q[j] <= OUT_W'(total >>> DROP_W);
        end
    end

endmodule

// File: rtl/dct8_valid_pipe.sv
module dct8_valid_pipe #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic vld_i,
    output logic vld_o
);

    logic [DEPTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= vld_i;
            for (int i = 1; i < DEPTH; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign vld_o = stage_q[DEPTH-1];

endmodule

// File: rtl/dct8_pipe_core.sv
module dct8_pipe_core
    import dct8_pkg::*;
#(
    parameter int IN_W   = 8,
    parameter int OUT_W  = 20,
    parameter int DROP_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [LANES*IN_W-1:0]    in_samples,
    output logic                     out_valid,
    output logic [LANES*OUT_W-1:0]   out_coefs
);

    localparam int S1_W = IN_W + 1;

    logic signed [IN_W-1:0]  samp     [LANES];
    logic signed [S1_W-1:0]  pair_sum [HALF];
    logic signed [S1_W-1:0]  pair_dif [HALF];
    logic signed [OUT_W-1:0] even_c   [HALF];
    logic signed [OUT_W-1:0] odd_c    [HALF];

    for (genvar n = 0; n < LANES; n++) begin : g_unpack
        assign samp[n] = in_samples[n*IN_W +: IN_W];
    end

    dct8_input_bfly #(.IN_W(IN_W)) bfly_i (
        .clk    (clk),
        .samp_i (samp),
        .sum_q  (pair_sum),
        .diff_q (pair_dif)
    );

    dct8_even_path #(.S1_W(S1_W), .OUT_W(OUT_W), .DROP_W(DROP_W)) even_i (
        .clk    (clk),
        .sum_i  (pair_sum),
        .coef_q (even_c)
    );

    dct8_odd_path #(.S1_W(S1_W), .OUT_W(OUT_W), .DROP_W(DROP_W)) odd_i (
        .clk    (clk),
        .diff_i (pair_dif),
        .coef_q (odd_c)
    );

    dct8_valid_pipe #(.DEPTH(LAT)) vpipe_i (
        .clk   (clk),
        .rst   (rst),
        .vld_i (in_valid),
        .vld_o (out_valid)
    );

    for (genvar j = 0; j < HALF; j++) begin : g_pack
        assign out_coefs[(2*j)*OUT_W   +: OUT_W] = even_c[j];
        assign out_coefs[(2*j+1)*OUT_W +: OUT_W] = odd_c[j];
    end

endmodule

// File: rtl/dct8_pipe_checker.sv
module dct8_pipe_checker
    import dct8_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 20
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [LANES*IN_W-1:0]  in_samples,
    input logic                   out_valid,
    input logic [LANES*OUT_W-1:0] out_coefs
);

    logic [2:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)               run_q <= '0;
        else if (run_q < 3'd4) run_q <= run_q + 3'd1;
    end

    logic sym_in, anti_in, odd_zero, even_zero;
    always_comb begin
        sym_in    = 1'b1;
        anti_in   = 1'b1;
        odd_zero  = 1'b1;
        even_zero = 1'b1;
        for (int n = 0; n < HALF; n++) begin
            if (in_samples[n*IN_W +: IN_W] != in_samples[(LANES-1-n)*IN_W +: IN_W])
                sym_in = 1'b0;
            if ((IN_W+1)'($signed(in_samples[n*IN_W +: IN_W]))
                + (IN_W+1)'($signed(in_samples[(LANES-1-n)*IN_W +: IN_W])) != '0)
                anti_in = 1'b0;
            if (out_coefs[(2*n+1)*OUT_W +: OUT_W] != '0) odd_zero  = 1'b0;
            if (out_coefs[(2*n)*OUT_W   +: OUT_W] != '0) even_zero = 1'b0;
        end
    end

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (run_q >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    p_reset_clear_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    p_sym_odd_zero_r7: assert property (@(posedge clk) disable iff (rst)
        ((run_q >= 3'd4) && $past(in_valid && sym_in, 4)) |-> odd_zero);

    p_anti_even_zero_r8: assert property (@(posedge clk) disable iff (rst)
        ((run_q >= 3'd4) && $past(in_valid && anti_in, 4)) |-> even_zero);

endmodule

bind dct8_pipe_core dct8_pipe_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_samples (in_samples),
    .out_valid  (out_valid),
    .out_coefs  (out_coefs)
);

// File: tb/dct8_pipe_core_tb_top.sv
module dct8_pipe_core_tb_top;

    localparam int IN_W  = 8;
    localparam int OUT_W = 20;
    localparam int LANES = 8;
    localparam int LAT   = 4;
    localparam real PI   = 3.14159265358979323846;
    localparam real TOL  = 3.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [LANES*IN_W-1:0]  in_samples = '0;
    logic                   out_valid;
    logic [LANES*OUT_W-1:0] out_coefs;

    always #2 clk = ~clk;

    dct8_pipe_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_samples (in_samples),
        .out_valid  (out_valid),
        .out_coefs  (out_coefs)
    );

    int checks = 0;
    int failures = 0;
    int out_seen = 0;
    bit finished = 1'b0;

    logic                  hval  [LAT];
    logic [LANES*IN_W-1:0] hvec  [LAT];
    int                    hkind [LAT];   // 0 plain, 1 symmetric, 2 antisymmetric
    string                 htag  [LAT];

    function automatic real ref_coef(logic [LANES*IN_W-1:0] v, int k);
        real acc = 0.0;
        for (int n = 0; n < LANES; n++) begin
            acc += real'($signed(v[n*IN_W +: IN_W])) * $cos(real'((2*n+1)*k) * PI / 16.0);
        end
        return acc * ((k == 0) ? $sqrt(0.125) : 0.5) * 64.0;
    endfunction

    function automatic logic [LANES*IN_W-1:0] rand_vec(int kind);
        logic [LANES*IN_W-1:0] v;
        v = {$urandom, $urandom};
        for (int n = 0; n < LANES/2; n++) begin
            int r;
            r = int'($urandom_range(254)) - 127;
            if (kind == 1) begin
                v[n*IN_W +: IN_W] = IN_W'(r);
                v[(LANES-1-n)*IN_W +: IN_W] = IN_W'(r);
            end else if (kind == 2) begin
                v[n*IN_W +: IN_W] = IN_W'(r);
                v[(LANES-1-n)*IN_W +: IN_W] = IN_W'(-r);
            end
        end
        return v;
    endfunction

    function automatic logic [LANES*IN_W-1:0] fill_vec(int val);
        logic [LANES*IN_W-1:0] v;
        for (int n = 0; n < LANES; n++) v[n*IN_W +: IN_W] = IN_W'(val);
        return v;
    endfunction

    task automatic clear_hist();
        for (int i = 0; i < LAT; i++) begin
            hval[i] = 1'b0; hvec[i] = '0; hkind[i] = 0; htag[i] = "";
        end
    endtask

    task automatic check_outputs();
        checks++;
        if (out_valid !== hval[LAT-1]) begin
            failures++;
            $display("FAIL R2 out_valid act=%0b exp=%0b", out_valid, hval[LAT-1]);
        end
        if (out_valid === 1'b1) out_seen++;
        if (hval[LAT-1]) begin
            for (int k = 0; k < LANES; k++) begin
                int  act;
                real expv;
                act = int'($signed(out_coefs[k*OUT_W +: OUT_W]));
                checks++;
                if ((hkind[LAT-1] == 1 && (k % 2) == 1) || (hkind[LAT-1] == 2 && (k % 2) == 0)) begin
                    if (act != 0) begin
                        failures++;
                        $display("FAIL %s coef%0d exact zero act=%0d exp=0",
                                 (hkind[LAT-1] == 1) ? "R7" : "R8", k, act);
                    end
                end else begin
                    expv = ref_coef(hvec[LAT-1], k);
                    if (real'(act) - expv > TOL || expv - real'(act) > TOL) begin
                        failures++;
                        $display("FAIL %s coef%0d act=%0d exp=%0.2f",
                                 (htag[LAT-1] != "") ? htag[LAT-1] : ((k == 0) ? "R6" : "R5"),
                                 k, act, expv);
                    end
                end
            end
        end
    endtask

    task automatic step(bit v, logic [LANES*IN_W-1:0] vec, int kind, string tag);
        @(negedge clk);
        check_outputs();
        for (int i = LAT-1; i > 0; i--) begin
            hval[i] = hval[i-1]; hvec[i] = hvec[i-1]; hkind[i] = hkind[i-1]; htag[i] = htag[i-1];
        end
        hval[0] = v; hvec[0] = vec; hkind[0] = kind; htag[0] = tag;
        in_valid   = v;
        in_samples = vec;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 0, "");
    endtask

    task automatic do_reset(int cycles);
        @(negedge clk);
        check_outputs();
        rst = 1'b1;
        in_valid = 1'b1;              // R3: valid held high during reset must be dropped
        in_samples = rand_vec(0);
        clear_hist();
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                failures++;
                $display("FAIL R3 out_valid during reset act=%0b exp=0", out_valid);
            end
        end
        rst = 1'b0;
        in_valid = 1'b0;
    endtask

    initial begin
        int base;
        void'($urandom(32'd20240611));
        clear_hist();
        do_reset(3);
        idle(4);   // R3: nothing valid emerges after reset

        // R1: impulse vectors pin the lane and coefficient field positions
        step(1'b1, {56'd0, 8'sd64}, 0, "R1");
        step(1'b1, {8'h9C, 56'd0}, 0, "R1");
        // R6 full-scale DC vectors (also symmetric, odd terms exactly zero per R7)
        step(1'b1, fill_vec(127),  1, "R6");
        step(1'b1, fill_vec(-128), 1, "R6");
        step(1'b1, fill_vec(0),    1, "R6");
        // R5 alternating extremes
        step(1'b1, {4{8'h80, 8'h7F}}, 0, "R5");
        step(1'b1, {4{8'h7F, 8'h80}}, 0, "R5");
        // R8 directed antisymmetric vector
        step(1'b1, {8'h81, 8'h05, 8'hC4, 8'h7F, 8'h81, 8'h3C, 8'hFB, 8'h7F}, 2, "R8");
        idle(LAT);

        // R4: back-to-back burst, every vector produces one output
        base = out_seen;
        for (int i = 0; i < 400; i++) step(1'b1, rand_vec(0), 0, "");
        idle(LAT + 1);
        checks++;
        if (out_seen - base != 400) begin
            failures++;
            $display("FAIL R4 burst outputs act=%0d exp=400", out_seen - base);
        end

        // R2/R5: random vectors with gaps and mixed kinds
        for (int i = 0; i < 400; i++) begin
            int kd;
            kd = int'($urandom_range(2));
            step(1'($urandom_range(1)), rand_vec(kd), kd, "");
        end

        // R3: reset with a full pipeline
        for (int i = 0; i < 3; i++) step(1'b1, rand_vec(0), 0, "");
        do_reset(2);
        idle(LAT);

        // R7 / R8 random structured vectors
        for (int i = 0; i < 50; i++) step(1'b1, rand_vec(1), 1, "R7");
        for (int i = 0; i < 50; i++) step(1'b1, rand_vec(2), 2, "R8");
        idle(LAT + 2);

        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule